// File: doc/BRIEF.md
# Multiprotocol Serial Character Transmitter

This block turns one parallel word at a time into a serial frame on a single output line. A frame can use one of three framings. The asynchronous framing has a low start bit, the data, optional parity, an optional ninth bit and a stop period of selectable length. The expansion framing keeps the start and stop slots, but both are dummy slots at the marking level and there is no parity. The synchronous framing sends only the data bits and, if enabled, the ninth bit. The data field is 5 to 8 bits long and goes out least significant bit first. When the ninth bit is enabled it comes after the data and any parity bit. Its value is carried with each word, so it can act as an address marker or as an extra data bit.

Bit timing comes from an external tick. When oversampling is selected, one bit lasts 16 ticks, and half-bit stop lengths are 8 extra ticks. Otherwise one bit lasts one tick. Words enter through a valid/ready port. `in_ready` is high whenever no frame is in progress, and this includes the cycle in which `done` pulses. A word transfers on a clock edge where `in_valid` and `in_ready` are both high. While a frame is in progress `in_ready` is low, so the sender must hold its word until the current frame ends. The configuration pins and the word are captured at the transfer edge. Changing them later has no effect on the frame already under way.

Top module: `mpx_char_tx`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0, `done` is 0 and `in_ready` is 1. The line stays at 1 whenever no frame is in progress.
- R2: A word is accepted on a clock edge with `in_valid` and `in_ready` both high, and `busy` rises at that edge. `in_ready` stays low while `busy` is high, and a word offered during that time does not alter the frame.
- R3: The data word, `in_ninth` and every configuration pin are captured at the acceptance edge. Changes made to them during a frame do not affect that frame.
- R4: The data field holds 5 + `cfg_len` bits (`cfg_len` is 0 to 3), sent from bit 0 upward. Data bits above the field length are not sent.
- R5: `cfg_mode` selects the framing: 0 is asynchronous, 1 is expansion, 2 and 3 are synchronous. In asynchronous framing the frame opens with one bit time at 0. In expansion framing it opens with one bit time at 1. In synchronous framing the first data bit comes first.
- R6: In asynchronous framing with `cfg_par_en`=1, a parity bit follows the data. With `cfg_par_odd`=0 it makes the number of ones across data and parity even; with `cfg_par_odd`=1 it makes that number odd. No parity bit is sent in the other framings.
- R7: With `cfg_ninth_en`=1, one bit carrying the captured `in_ninth` value follows the data and parity fields in every framing.
- R8: With `cfg_x16`=1 a bit lasts 16 ticks; with `cfg_x16`=0 it lasts 1 tick. `txd` changes only at clock edges where `tick` is high, apart from the acceptance edge.
- R9: The asynchronous stop period is high. With `cfg_x16`=1 it lasts 16, 24, 32 or 40 ticks for `cfg_stop` = 0, 1, 2, 3. With `cfg_x16`=0 it lasts 1, 2, 3 or 3 ticks for those codes.
- R10: The expansion framing ends with a stop slot of one bit time at 1, whatever the value of `cfg_stop`. The synchronous framing has no stop slot.
- R11: `done` is high for exactly one clock, starting at the edge that consumes the final tick of the last field. `busy` falls at that same edge, and a new word may be accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Bit-rate tick from the external baud generator |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be accepted (idle) |
| in_data | input | DATA_W | Data word, bit 0 sent first |
| in_ninth | input | 1 | Value of the ninth/address bit |
| cfg_mode | input | 2 | Framing: 0 async, 1 expansion, 2/3 synchronous |
| cfg_len | input | 2 | Data length minus 5 |
| cfg_par_en | input | 1 | Parity enable (async only) |
| cfg_par_odd | input | 1 | 1 odd, 0 even parity |
| cfg_ninth_en | input | 1 | Send the ninth bit |
| cfg_stop | input | 2 | Stop length code |
| cfg_x16 | input | 1 | 1: 16 ticks per bit, 0: 1 tick per bit |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse at the end of a frame |

## Verification
The bench targets the fractional stop lengths of 24 and 40 ticks. A design that timed half bits wrongly, or that used the oversampled table while in 1x mode, would produce a stop run of the wrong length and a late or early `done`. Odd parity over an all-zero word and a 5-bit word with ones in its unused upper bits are both covered. A parity unit that ignored the field length would send the wrong parity bit, and a design that leaked the upper bits would send the wrong data bits. The expansion and synchronous framings are run with parity and a long stop code selected, and the bench then looks for extra slots, because those settings must have no effect there. While each frame runs, the bench keeps `in_valid` high at random and scrambles the word and the configuration pins. A design that resampled its inputs, or that accepted a word while busy, would corrupt the tick-by-tick line trace the bench compares.

// File: rtl/mpx_tx_pkg.sv
package mpx_tx_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC    = 2'd0,
    MODE_EXPAN    = 2'd1,
    MODE_SYNC     = 2'd2,
    MODE_SYNC_ALT = 2'd3
  } tx_mode_e;

  typedef enum logic [2:0] {
    F_IDLE   = 3'd0,
    F_START  = 3'd1,
    F_DATA   = 3'd2,
    F_PARITY = 3'd3,
    F_NINTH  = 3'd4,
    F_STOP   = 3'd5
  } field_e;

  typedef struct packed {
    tx_mode_e   mode;
    logic [1:0] len_sel;
    logic       par_en;
    logic       par_odd;
    logic       ninth_en;
    logic [1:0] stop_sel;
    logic       x16;
  } tx_cfg_t;

  // synchronous framing has no start or stop slot
  function automatic logic is_sync(tx_mode_e m);
    return m[1];
  endfunction

  // field that follows f; F_IDLE means the frame is complete
  function automatic field_e follow(field_e f, tx_cfg_t c);
    field_e n;
    case (f)
      F_START: n = F_DATA;
      F_DATA: begin
        if (c.mode == MODE_ASYNC && c.par_en) n = F_PARITY;
        else if (c.ninth_en)                  n = F_NINTH;
        else if (!is_sync(c.mode))            n = F_STOP;
        else                                  n = F_IDLE;
      end
      F_PARITY: n = c.ninth_en ? F_NINTH : F_STOP;
      F_NINTH:  n = is_sync(c.mode) ? F_IDLE : F_STOP;
      default:  n = F_IDLE;
    endcase
    return n;
  endfunction

  // ticks spent in one field, given the oversampling ratio
  function automatic int unsigned field_len(field_e f, tx_cfg_t c, int unsigned ovs);
    int unsigned bit_t;
    int unsigned r;
    bit_t = c.x16 ? ovs : 1;
    r = bit_t;
    if (f == F_STOP && c.mode == MODE_ASYNC) begin
      if (c.x16) r = ovs + int'(c.stop_sel) * (ovs / 2);
      else       r = (c.stop_sel == 2'd3) ? 3 : int'(c.stop_sel) + 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/mpx_tx_parity.sv
module mpx_tx_parity #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic [DATA_W-1:0] data,
  input  logic [LEN_W-1:0]  len,
  input  logic              odd,
  output logic              par
);
  logic [DATA_W-1:0] kept;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign kept[i] = data[i] & (LEN_W'(i) < len);
  end

  // even: ones(data)+par even; odd: that count odd
  assign par = (^kept) ^ odd;
endmodule

// File: rtl/mpx_tx_bit_timer.sv
module mpx_tx_bit_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] target,
  output logic             field_end
);
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last      = (cnt_q == target - CNT_W'(1));
  assign field_end = active && tick && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (active && tick) begin
      cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
    end
  end

  // R8: the counter never runs past the length of the current field
  p_cnt_in_field_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q < target));
endmodule

// File: rtl/mpx_tx_field_seq.sv
module mpx_tx_field_seq
  import mpx_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  parameter int OVS     = 16,
  parameter int CNT_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  tx_cfg_t           start_cfg,
  input  logic [DATA_W-1:0] start_data,
  input  logic              start_ninth,
  input  logic              field_end,
  output field_e            field,
  output logic [CNT_W-1:0]  field_ticks,
  output logic              line,
  output logic              done
);
  localparam int LEN_W = $clog2(DATA_W + 1);
  localparam int IDX_W = $clog2(DATA_W);

  field_e            field_q;
  tx_cfg_t           cfg_q;
  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic              par_q;
  logic              ninth_q;
  logic              done_q;
  logic [LEN_W-1:0]  start_len;
  logic [LEN_W-1:0]  cur_len;
  logic              start_par;
  logic              data_last;
  field_e            after;

  assign start_len = LEN_W'(MIN_LEN) + LEN_W'(start_cfg.len_sel);
  assign cur_len   = LEN_W'(MIN_LEN) + LEN_W'(cfg_q.len_sel);
  assign data_last = (LEN_W'(idx_q) == cur_len - LEN_W'(1));

  mpx_tx_parity #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_par (
    .data (start_data),
    .len  (start_len),
    .odd  (start_cfg.par_odd),
    .par  (start_par)
  );

  always_comb begin
    after = follow(field_q, cfg_q);
    if (field_q == F_DATA && !data_last) after = F_DATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= F_IDLE;
      cfg_q   <= '0;
      sh_q    <= '0;
      idx_q   <= '0;
      par_q   <= 1'b0;
      ninth_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        cfg_q   <= start_cfg;
        sh_q    <= start_data;
        idx_q   <= '0;
        par_q   <= start_par;
        ninth_q <= start_ninth;
        field_q <= is_sync(start_cfg.mode) ? F_DATA : F_START;
      end else if (field_end) begin
        field_q <= after;
        if (field_q == F_DATA && !data_last) begin
          sh_q  <= sh_q >> 1;
          idx_q <= idx_q + IDX_W'(1);
        end
        if (after == F_IDLE) done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (field_q)
      F_START:  line = (cfg_q.mode != MODE_ASYNC);
      F_DATA:   line = sh_q[0];
      F_PARITY: line = par_q;
      F_NINTH:  line = ninth_q;
      default:  line = 1'b1;
    endcase
  end

  assign field       = field_q;
  assign field_ticks = CNT_W'(field_len(field_q, cfg_q, OVS));
  assign done        = done_q;

  // R4: the bit index stays inside the programmed data length
  p_idx_in_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (field_q == F_DATA) |-> (LEN_W'(idx_q) < cur_len));
  // R6: a parity slot appears only in the asynchronous framing
  p_parity_async_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (field_q == F_PARITY) |-> (cfg_q.mode == MODE_ASYNC && cfg_q.par_en));
  // R5 / R10: synchronous framing visits only data and ninth-bit slots
  p_sync_bare_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (field_q != F_IDLE && is_sync(cfg_q.mode)) |-> (field_q == F_DATA || field_q == F_NINTH));
  // R3: the captured configuration holds for the whole frame
  p_cfg_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (field_q != F_IDLE && !start) |=> (field_q == F_IDLE || $stable(cfg_q)));
endmodule

// File: rtl/mpx_char_tx.sv
module mpx_char_tx
  import mpx_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  parameter int OVS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_ninth,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_ninth_en,
  input  logic [1:0]        cfg_stop,
  input  logic              cfg_x16,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = $clog2(OVS * 3 + 1);

  tx_cfg_t          cfg_in;
  field_e           field;
  logic [CNT_W-1:0] field_ticks;
  logic             accept;
  logic             field_end;
  logic             active;

  assign cfg_in = '{mode: tx_mode_e'(cfg_mode), len_sel: cfg_len, par_en: cfg_par_en,
                    par_odd: cfg_par_odd, ninth_en: cfg_ninth_en, stop_sel: cfg_stop,
                    x16: cfg_x16};

  assign active   = (field != F_IDLE);
  assign in_ready = !active;
  assign busy     = active;
  assign accept   = in_valid && in_ready;

  mpx_tx_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .restart   (accept),
    .tick      (tick),
    .target    (field_ticks),
    .field_end (field_end)
  );

  mpx_tx_field_seq #(
    .DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .OVS(OVS), .CNT_W(CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_cfg   (cfg_in),
    .start_data  (in_data),
    .start_ninth (in_ninth),
    .field_end   (field_end),
    .field       (field),
    .field_ticks (field_ticks),
    .line        (txd),
    .done        (done)
  );

  // R2: an accepted word always starts a frame
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);
  // R11: done lasts a single clock
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11: done coincides with the return to idle on a marking line
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && txd));
  // R1: marking level whenever idle
  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R8: nothing moves on a clock without a tick
  p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> (busy && $stable(txd)));
endmodule

// File: tb/mpx_char_tx_bench.sv
module mpx_char_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_ninth = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic [1:0] cfg_len = '0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_ninth_en = 1'b0;
  logic [1:0] cfg_stop = '0;
  logic       cfg_x16 = 1'b0;
  logic       txd;
  logic       busy;
  logic       done;

  int checks = 0;
  int fails = 0;
  int tick_period = 1;
  int frame_no = 0;

  logic exp_bit [0:511];
  int   exp_req [0:511];
  int   exp_n;

  always #10 clk = ~clk;

  mpx_char_tx u_mpx_char_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ninth(in_ninth), .cfg_mode(cfg_mode), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_ninth_en(cfg_ninth_en),
    .cfg_stop(cfg_stop), .cfg_x16(cfg_x16), .txd(txd), .busy(busy), .done(done)
  );

  // tick generator: one-clock pulse every tick_period clocks
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk);
      #1;
      cnt++;
      if (cnt >= tick_period) begin tick = 1'b1; cnt = 0; end
      else tick = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s frame %0d %s: actual=%0d expected=%0d", req, frame_no, what, act, exp);
    end
  endtask

  task automatic push(input logic v, input int req, input int n);
    for (int k = 0; k < n; k++) begin
      exp_bit[exp_n] = v;
      exp_req[exp_n] = req;
      exp_n++;
    end
  endtask

  // reference line trace, one entry per tick
  task automatic build(input logic [7:0] d, input logic nb, input int mode, input int lsel,
                       input bit pen, input bit podd, input bit nen, input int ssel, input bit x16);
    int bt;
    int len;
    int ones;
    int st;
    bt = x16 ? 16 : 1;
    len = 5 + lsel;
    exp_n = 0;
    if (mode == 0) push(1'b0, 5, bt);                          // R5 real start
    else if (mode == 1) push(1'b1, 5, bt);                     // R5 dummy start
    ones = 0;
    for (int i = 0; i < len; i++) begin
      push(d[i], 4, bt);                                       // R4 LSB first
      ones += int'(d[i]);
    end
    if (mode == 0 && pen) push(((ones % 2) == 1) ^ podd, 6, bt); // R6
    if (nen) push(nb, 7, bt);                                  // R7
    if (mode == 0) begin                                       // R9
      if (x16) st = 16 + 8 * ssel;
      else st = (ssel == 3) ? 3 : ssel + 1;
      push(1'b1, 9, st);
    end else if (mode == 1) push(1'b1, 10, bt);                // R10
  endtask

  task automatic run_frame(input logic [7:0] d, input logic nb, input int mode, input int lsel,
                           input bit pen, input bit podd, input bit nen, input int ssel,
                           input bit x16, input int tp);
    int idx;
    frame_no++;
    build(d, nb, mode, lsel, pen, podd, nen, ssel, x16);
    @(negedge clk);
    tick_period = tp;
    in_data = d; in_ninth = nb; cfg_mode = 2'(mode); cfg_len = 2'(lsel);
    cfg_par_en = pen; cfg_par_odd = podd; cfg_ninth_en = nen; cfg_stop = 2'(ssel);
    cfg_x16 = x16; in_valid = 1'b1;
    check(in_ready === 1'b1, "R2", "ready before offer", int'(in_ready), 1);
    @(negedge clk);
    check(busy === 1'b1, "R2", "busy after accept", int'(busy), 1);
    // R3 / R2: scramble inputs and keep offering while busy
    in_valid = 1'($urandom_range(0, 1));
    in_data = 8'($urandom); in_ninth = 1'($urandom);
    cfg_mode = 2'($urandom); cfg_len = 2'($urandom); cfg_par_en = 1'($urandom);
    cfg_par_odd = 1'($urandom); cfg_ninth_en = 1'($urandom); cfg_stop = 2'($urandom);
    cfg_x16 = 1'($urandom);
    idx = 0;
    forever begin
      if (tick) begin
        checks++;
        if (txd !== exp_bit[idx]) begin
          fails++;
          $display("FAIL R%0d frame %0d tick %0d: txd actual=%0b expected=%0b",
                   exp_req[idx], frame_no, idx, txd, exp_bit[idx]);
        end
        check(in_ready === 1'b0, "R2", "ready during frame", int'(in_ready), 0);
        idx++;
        if (idx == exp_n) begin in_valid = 1'b0; break; end
      end
      @(negedge clk);
    end
    @(negedge clk);
    check(done === 1'b1, "R11", "done after last tick", int'(done), 1);
    check(busy === 1'b0, "R11", "busy after last tick", int'(busy), 0);
    check(txd === 1'b1, "R1", "line idle after frame", int'(txd), 1);
    @(negedge clk);
    check(done === 1'b0, "R11", "done width", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txd === 1'b1, "R1", "reset txd", int'(txd), 1);
    check(busy === 1'b0, "R1", "reset busy", int'(busy), 0);
    check(done === 1'b0, "R1", "reset done", int'(done), 0);
    check(in_ready === 1'b1, "R1", "reset ready", int'(in_ready), 1);

    void'($urandom(32'h5EED_0042));
    // directed corners
    run_frame(8'hA5, 1'b1, 0, 3, 1, 0, 1, 1, 1, 1); // R9 1.5-bit stop, x16
    run_frame(8'h00, 1'b0, 0, 3, 1, 1, 0, 3, 1, 2); // R6 odd parity of zeros, R9 2.5 stop
    run_frame(8'hE0, 1'b0, 0, 0, 1, 0, 0, 0, 0, 1); // R4 5 bits, upper ones dropped
    run_frame(8'h3C, 1'b1, 1, 3, 1, 1, 1, 3, 0, 1); // R10 expansion ignores parity and stop
    run_frame(8'h96, 1'b1, 2, 2, 1, 0, 1, 2, 1, 3); // R5 synchronous bare with ninth
    run_frame(8'h5A, 1'b0, 3, 1, 0, 0, 0, 0, 0, 1); // R5 mode 3 synchronous
    run_frame(8'h81, 1'b1, 0, 3, 0, 0, 0, 3, 0, 2); // R9 1x code 3 gives 3 ticks
    // R8 / R3 random frames
    for (int f = 0; f < 40; f++) begin
      run_frame(8'($urandom), 1'($urandom), int'($urandom_range(0, 3)),
                int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom_range(0, 3)), 1'($urandom), int'($urandom_range(1, 3)));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R11 watchdog: frame %0d never completed", frame_no);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule